// File: doc/BRIEF.md
# SATA PLL Power Sequencer

This block steps a SATA PHY PLL and its analog pad into and out of low-power state. It keeps two control-register images, one for the pad and one for the PLL, and changes one field group per step in a fixed order. A pulse on `start_up_i` wakes the pad and the PLL, selects PLL operating mode and releases the PLL reset. It then polls `lock_detect_i` within a bounded number of tries. A pulse on `start_down_i` undoes the same steps in reverse order and waits a programmable time after each one.

The two directions are timed differently. Power-up makes its four writes on consecutive clock cycles and then polls lock. Each failed poll is followed by a wait of `WAIT_CYCLES` before the next try. The poll count runs from `POLL_INIT` down to zero. A lock first seen when the count has already reached zero is still reported as a timeout. Power-down follows every write with a full `WAIT_CYCLES` wait. Each sequence ends with a one-cycle `done_o`, and `timeout_o` is raised in that same cycle when the power-up failed.

Top module: `sata_pll_pwr_seq`

## Requirements
- R1: After reset both pad bits are 1, PLL power override and PLL IDDQ are 1, PLL mode and reset release are 0, and busy_o, done_o and timeout_o are 0 (pad image 2'b11, PLL image 32'h0000_0009 while lock_detect_i is low).
- R2: Power-up changes the images on four consecutive clock edges, the first being the edge that samples start_up_i: first pad bits cleared, then PLL override and IDDQ cleared, then mode set, then reset release set.
- R3: The first lock poll is on the edge after reset release. Each failed poll that is not the last is followed by a WAIT_CYCLES wait, and the next poll comes one edge after that wait. A lock seen at poll k (0 <= k < POLL_INIT) ends the sequence with done_o at 4 + k*(WAIT_CYCLES+1) edges after the start edge, and timeout_o stays low.
- R4: A lock first seen at the last poll (k = POLL_INIT, count zero) ends the sequence at the same point in time but with timeout_o high.
- R5: If no poll sees lock, done_o and timeout_o come WAIT_CYCLES edges after the last poll, and the images keep their powered-up values (pad 2'b00, PLL mode and reset release set).
- R6: Power-down changes the images on the start edge and then after every further WAIT_CYCLES edges, in this order: reset release cleared, mode cleared, PLL override and IDDQ set, pad bits set. done_o follows 4*WAIT_CYCLES edges after the start edge.
- R7: done_o is a single-cycle pulse. timeout_o is only ever high together with done_o. busy_o is high from the edge after a start until the edge that raises done_o, and low while done_o is high.
- R8: While busy_o is high, start_up_i and start_down_i are ignored. If both are high while idle, power-up is chosen. While idle and not starting, the images do not change.
- R9: Image layout: pad bit 1 = IDDQ override, bit 0 = IDDQ. PLL bit 27 = lock_detect_i, bit 24 = mode, bit 3 = power override, bit 1 = reset release (1 = running), bit 0 = IDDQ. All other PLL bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_up_i | input | 1 | Begin power-up (sampled while idle) |
| start_down_i | input | 1 | Begin power-down (sampled while idle) |
| lock_detect_i | input | 1 | PLL lock indication |
| pad_ctl_o | output | 2 | Pad control register image |
| pll_ctl_o | output | 32 | PLL control register image |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| timeout_o | output | 1 | Power-up failed to lock; only with done_o |

## Verification
Every result has a known due edge counted from the start edge. The power-up writes land on edges 0 to 3. Poll k falls on edge 4 + k*(WAIT_CYCLES+1). A failed final poll reports at that edge plus WAIT_CYCLES, and power-down writes land on edges 0, W, 2W, 3W with done_o at 4W. The driver records the start edge and pushes the expected latency, timeout flag and both images into a scoreboard queue. The monitor pops that entry on the negative edge where done_o appears and compares the measured edge count. The lock input is placed by edge number, so that it first rises just before the chosen poll. Intermediate image values are sampled on the negative edge after each expected write.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;
  localparam int PAD_REG_W        = 2;
  localparam int PAD_OVRD_BIT     = 1;
  localparam int PAD_IDDQ_BIT     = 0;

  localparam int PLL_REG_W        = 32;
  localparam int PLL_LOCK_BIT     = 27;
  localparam int PLL_MODE_BIT     = 24;
  localparam int PLL_PWR_OVRD_BIT = 3;
  localparam int PLL_RUN_BIT      = 1;
  localparam int PLL_IDDQ_BIT     = 0;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_PAD_WAKE,
    OP_PLL_WAKE,
    OP_MODE_ON,
    OP_RUN,
    OP_HALT,
    OP_MODE_OFF,
    OP_PLL_SLEEP,
    OP_PAD_SLEEP
  } reg_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UP_STEP,
    ST_POLL,
    ST_POLL_WAIT,
    ST_DN_WAIT
  } seq_state_e;
endpackage

// File: rtl/pllseq_timer.sv
module pllseq_timer #(
  parameter int WAIT_CYCLES = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic zero_o
);
  localparam int TW = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
  localparam logic [TW-1:0] RELOAD = TW'(WAIT_CYCLES - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= RELOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pllseq_regs.sv
module pllseq_regs
  import pllseq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  reg_op_e              op_i,
  input  logic                 lock_i,
  output logic [PAD_REG_W-1:0] pad_o,
  output logic [PLL_REG_W-1:0] pll_o
);
  logic pad_ovrd_q, pad_iddq_q;
  logic pwr_ovrd_q, pll_iddq_q, mode_q, run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pad_ovrd_q <= 1'b1;
      pad_iddq_q <= 1'b1;
      pwr_ovrd_q <= 1'b1;
      pll_iddq_q <= 1'b1;
      mode_q     <= 1'b0;
      run_q      <= 1'b0;
    end else begin
      unique case (op_i)
        OP_PAD_WAKE:  begin pad_ovrd_q <= 1'b0; pad_iddq_q <= 1'b0; end
        OP_PLL_WAKE:  begin pwr_ovrd_q <= 1'b0; pll_iddq_q <= 1'b0; end
        OP_MODE_ON:   mode_q <= 1'b1;
        OP_RUN:       run_q  <= 1'b1;
        OP_HALT:      run_q  <= 1'b0;
        OP_MODE_OFF:  mode_q <= 1'b0;
        OP_PLL_SLEEP: begin pwr_ovrd_q <= 1'b1; pll_iddq_q <= 1'b1; end
        OP_PAD_SLEEP: begin pad_ovrd_q <= 1'b1; pad_iddq_q <= 1'b1; end
        default: ;
      endcase
    end
  end

  always_comb begin
    pad_o               = '0;
    pad_o[PAD_OVRD_BIT] = pad_ovrd_q;
    pad_o[PAD_IDDQ_BIT] = pad_iddq_q;
    pll_o                   = '0;
    pll_o[PLL_LOCK_BIT]     = lock_i;
    pll_o[PLL_MODE_BIT]     = mode_q;
    pll_o[PLL_PWR_OVRD_BIT] = pwr_ovrd_q;
    pll_o[PLL_RUN_BIT]      = run_q;
    pll_o[PLL_IDDQ_BIT]     = pll_iddq_q;
  end
endmodule

// File: rtl/pllseq_fsm.sv
module pllseq_fsm
  import pllseq_pkg::*;
#(
  parameter int POLL_INIT = 100
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_up_i,
  input  logic    start_down_i,
  input  logic    lock_i,
  input  logic    tmr_zero_i,
  output logic    tmr_load_o,
  output reg_op_e op_o,
  output logic    busy_o,
  output logic    done_o,
  output logic    timeout_o
);
  localparam int PW = (POLL_INIT > 0) ? $clog2(POLL_INIT + 1) : 1;
  localparam logic [PW-1:0] POLL_START = PW'(POLL_INIT);

  seq_state_e    state_q, state_d;
  logic [1:0]    step_q, step_d;
  logic [PW-1:0] poll_q, poll_d;
  logic          done_d, to_d;
  logic          done_q, to_q;

  always_comb begin
    state_d    = state_q;
    step_d     = step_q;
    poll_d     = poll_q;
    op_o       = OP_NONE;
    tmr_load_o = 1'b0;
    done_d     = 1'b0;
    to_d       = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_up_i) begin            // up wins over down
          op_o    = OP_PAD_WAKE;
          step_d  = 2'd1;
          state_d = ST_UP_STEP;
        end else if (start_down_i) begin
          op_o       = OP_HALT;
          step_d     = 2'd0;
          tmr_load_o = 1'b1;
          state_d    = ST_DN_WAIT;
        end
      end
      ST_UP_STEP: begin
        step_d = 2'(step_q + 2'd1);
        unique case (step_q)
          2'd1:    op_o = OP_PLL_WAKE;
          2'd2:    op_o = OP_MODE_ON;
          default: begin
            op_o    = OP_RUN;
            poll_d  = POLL_START;
            state_d = ST_POLL;
          end
        endcase
      end
      ST_POLL: begin
        if (lock_i) begin
          done_d  = 1'b1;
          to_d    = (poll_q == '0);   // lock at last count still fails
          state_d = ST_IDLE;
        end else begin
          tmr_load_o = 1'b1;
          state_d    = ST_POLL_WAIT;
        end
      end
      ST_POLL_WAIT: begin
        if (tmr_zero_i) begin
          if (poll_q == '0) begin
            done_d  = 1'b1;
            to_d    = 1'b1;
            state_d = ST_IDLE;
          end else begin
            poll_d  = poll_q - 1'b1;
            state_d = ST_POLL;
          end
        end
      end
      ST_DN_WAIT: begin
        if (tmr_zero_i) begin
          if (step_q == 2'd3) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            step_d     = 2'(step_q + 2'd1);
            tmr_load_o = 1'b1;
            unique case (step_q)
              2'd0:    op_o = OP_MODE_OFF;
              2'd1:    op_o = OP_PLL_SLEEP;
              default: op_o = OP_PAD_SLEEP;
            endcase
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      poll_q  <= '0;
      done_q  <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      poll_q  <= poll_d;
      done_q  <= done_d;
      to_q    <= to_d;
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign timeout_o = to_q;
endmodule

// File: rtl/sata_pll_pwr_seq.sv
module sata_pll_pwr_seq
  import pllseq_pkg::*;
#(
  parameter int WAIT_CYCLES = 10000,
  parameter int POLL_INIT   = 100
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_up_i,
  input  logic                 start_down_i,
  input  logic                 lock_detect_i,
  output logic [PAD_REG_W-1:0] pad_ctl_o,
  output logic [PLL_REG_W-1:0] pll_ctl_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 timeout_o
);
  reg_op_e op;
  logic    tmr_load, tmr_zero;

  pllseq_fsm #(.POLL_INIT(POLL_INIT)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_up_i   (start_up_i),
    .start_down_i (start_down_i),
    .lock_i       (lock_detect_i),
    .tmr_zero_i   (tmr_zero),
    .tmr_load_o   (tmr_load),
    .op_o         (op),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .timeout_o    (timeout_o)
  );

  pllseq_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .zero_o (tmr_zero)
  );

  pllseq_regs u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op),
    .lock_i (lock_detect_i),
    .pad_o  (pad_ctl_o),
    .pll_o  (pll_ctl_o)
  );
endmodule

// File: rtl/pllseq_checker.sv
module pllseq_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [1:0]  pad_ctl_o,
  input logic [31:0] pll_ctl_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        timeout_o
);
  assert_timeout_with_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> done_o);

  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_not_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R2 / R6 ordering: run needs mode, mode needs PLL powered, PLL powered needs pad awake
  assert_run_needs_mode_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_ctl_o[1] |-> pll_ctl_o[24]);

  assert_mode_needs_power_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_ctl_o[24] |-> (!pll_ctl_o[3] && !pll_ctl_o[0]));

  assert_pll_needs_pad_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pll_ctl_o[0] |-> !pad_ctl_o[0]);

  assert_idle_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o)) |->
      $stable({pad_ctl_o, pll_ctl_o[24], pll_ctl_o[3], pll_ctl_o[1], pll_ctl_o[0]}));
endmodule

bind sata_pll_pwr_seq pllseq_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pad_ctl_o (pad_ctl_o),
  .pll_ctl_o (pll_ctl_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .timeout_o (timeout_o)
);

// File: tb/sata_pll_pwr_seq_tb_top.sv
`timescale 1ns/1ps
module sata_pll_pwr_seq_tb_top;
  localparam int W = 3;
  localparam int P = 4;
  localparam int NEVER = 32'h7fff_ffff;
  localparam logic [31:0] PLL_OFF  = 32'h0000_0009;
  localparam logic [31:0] PLL_ON_L = 32'h0900_0002;
  localparam logic [31:0] PLL_ON_N = 32'h0100_0002;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_up = 1'b0, start_dn = 1'b0, lock = 1'b0;
  logic [1:0]  pad;
  logic [31:0] pll;
  logic        busy, done, tmo;

  int cyc = 0, lock_cyc = NEVER, start_cyc = 0;
  int n_checks = 0, n_fail = 0, pushes = 0, pops = 0;
  logic prev_done = 1'b0;

  typedef struct {
    int          lat;
    logic        to;
    logic [1:0]  pad;
    logic [31:0] pll;
    string       req;
  } exp_t;
  exp_t sb_q[$];
  exp_t e;

  always #5 clk = ~clk;

  sata_pll_pwr_seq #(.WAIT_CYCLES(W), .POLL_INIT(P)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_up_i(start_up), .start_down_i(start_dn),
    .lock_detect_i(lock), .pad_ctl_o(pad), .pll_ctl_o(pll),
    .busy_o(busy), .done_o(done), .timeout_o(tmo)
  );

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) begin
    #1 lock = (cyc >= lock_cyc);
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (sb_q.size() == 0) begin
          check("R8 unexpected done", 32'd1, 32'd0);
        end else begin
          e = sb_q.pop_front();
          check({e.req, " latency"}, 32'(cyc - start_cyc), 32'(e.lat));
          check({e.req, " timeout"}, {31'd0, tmo}, {31'd0, e.to});
          check({e.req, " pad"},     {30'd0, pad}, {30'd0, e.pad});
          check({e.req, " pll"},     pll, e.pll);
          check("R7 busy low at done", {31'd0, busy}, 32'd0);
          pops++;
        end
        if (prev_done) check("R7 done width", 32'd1, 32'd0);
      end
      if (tmo && !done) check("R7 timeout without done", 32'd1, 32'd0);
      prev_done = done;
    end
  end

  // driver: push expectation, pulse start; returns at negedge after start edge
  task automatic drive(bit up, bit dn, int lock_at, int lat, logic to,
                       logic [1:0] xpad, logic [31:0] xpll, string req);
    exp_t x;
    @(negedge clk);
    x.lat = lat; x.to = to; x.pad = xpad; x.pll = xpll; x.req = req;
    sb_q.push_back(x);
    pushes++;
    start_cyc = cyc + 1;
    lock_cyc  = (lock_at < 0) ? NEVER : (start_cyc + 3 + lock_at * (W + 1));
    start_up = up;
    start_dn = dn;
    @(negedge clk);
    start_up = 1'b0;
    start_dn = 1'b0;
  endtask

  task automatic wait_done();
    while (pops < pushes) @(negedge clk);
  endtask

  task automatic power_down(string req);
    drive(1'b0, 1'b1, -1, 4 * W, 1'b0, 2'b11, PLL_OFF, req);
    wait_done();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pad reset", {30'd0, pad}, 32'd3);
    check("R1 pll reset R9", pll, PLL_OFF);
    check("R1 busy reset", {31'd0, busy}, 32'd0);
    check("R1 done reset", {30'd0, done, tmo}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after release", {30'd0, pad}, 32'd3);

    // R2 + R3: lock appears at poll 1
    drive(1'b1, 1'b0, 1, 4 + 1 * (W + 1), 1'b0, 2'b00, PLL_ON_L, "R3 lock at poll 1");
    check("R2 step0 pad", {30'd0, pad}, 32'd0);
    check("R2 step0 pll", pll, PLL_OFF);
    check("R7 busy after start", {31'd0, busy}, 32'd1);
    @(negedge clk);
    check("R2 step1 pll", pll, 32'h0);
    @(negedge clk);
    check("R2 step2 pll", pll, 32'h0100_0000);
    @(negedge clk);
    check("R2 step3 pll R9", pll, PLL_ON_N);
    wait_done();

    // R6 power-down with intermediate steps
    drive(1'b0, 1'b1, -1, 4 * W, 1'b0, 2'b11, PLL_OFF, "R6 power-down");
    check("R6 step0 pll", pll, 32'h0100_0000);
    check("R6 step0 pad", {30'd0, pad}, 32'd0);
    repeat (W) @(negedge clk);
    check("R6 step1 pll", pll, 32'h0);
    repeat (W) @(negedge clk);
    check("R6 step2 pll", pll, PLL_OFF);
    check("R6 step2 pad", {30'd0, pad}, 32'd0);
    repeat (W) @(negedge clk);
    check("R6 step3 pad", {30'd0, pad}, 32'd3);
    wait_done();

    // R3 immediate lock
    drive(1'b1, 1'b0, 0, 4, 1'b0, 2'b00, PLL_ON_L, "R3 lock at first poll");
    wait_done();
    power_down("R6 power-down 2");

    // R3 lock at last counted poll
    drive(1'b1, 1'b0, P - 1, 4 + (P - 1) * (W + 1), 1'b0, 2'b00, PLL_ON_L, "R3 lock at poll P-1");
    wait_done();
    power_down("R6 power-down 3");

    // R4 lock at count zero
    drive(1'b1, 1'b0, P, 4 + P * (W + 1), 1'b1, 2'b00, PLL_ON_L, "R4 lock at count zero");
    wait_done();
    power_down("R6 power-down 4");

    // R5 never locks
    drive(1'b1, 1'b0, -1, 4 + P * (W + 1) + W, 1'b1, 2'b00, PLL_ON_N, "R5 no lock");
    wait_done();

    // R8 starts while busy are ignored
    drive(1'b0, 1'b1, -1, 4 * W, 1'b0, 2'b11, PLL_OFF, "R8 down with ignored starts");
    repeat (3) @(negedge clk);
    start_up = 1'b1;
    start_dn = 1'b1;
    @(negedge clk);
    start_up = 1'b0;
    start_dn = 1'b0;
    wait_done();
    repeat (3) @(negedge clk);
    check("R8 idle after ignored start busy", {31'd0, busy}, 32'd0);
    check("R8 idle after ignored start pad", {30'd0, pad}, 32'd3);
    check("R8 idle after ignored start pll", pll, PLL_OFF);

    // R8 both starts while idle -> power-up
    drive(1'b1, 1'b1, 0, 4, 1'b0, 2'b00, PLL_ON_L, "R8 up wins");
    wait_done();
    repeat (3) @(negedge clk);
    check("R8 no further done", 32'(pops), 32'(pushes));

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule